// File: doc/BRIEF.md
# Colour-Cell VGA Raster Renderer

This block generates a 640x480 VGA raster and fills it with square 8x8 pixel tiles. Each tile shows one solid colour, and that colour is one byte in video RAM. The block holds its own horizontal and vertical position counters. It decodes active-low sync pulses and an active-video flag from those counters. It drives a read address into a synchronous video-RAM port and presents an 8-bit colour for every pixel clock.

Video RAM holds an 80 by 60 array of tile bytes, 4800 bytes in all, so it fits within an 8 KiB space. A byte is read once for every 8 pixels, which at a 25.175 MHz dot clock is about 3.15 MHz. Each tile's byte is requested one tile ahead of the point where it is needed. The byte has therefore been captured by the tile's first pixel and is held for the tile's 8 pixels. The same address is read again on each of the tile's 8 lines. The byte goes straight to the colour output during visible time, and the colour output is zero in blanking.

Top module: `cellvid_top`

## Requirements
- R1: A line lasts 800 clocks (x = 0..799). `hsync_n` is low exactly for x in 656..751 and high otherwise.
- R2: A frame lasts 525 lines (y = 0..524). `vsync_n` is low for all of lines 490 and 491 and high on every other line.
- R3: `active` is high exactly when x < 640 and y < 480.
- R4: While `active` is high, `colour` equals the RAM byte at address (y/8)*80 + x/8. Every pixel of an 8x8 tile shows the same byte, starting at the tile's first pixel.
- R5: `colour` is 8'h00 whenever `active` is low.
- R6: A fetch is a one-clock pulse of `vram_rd`. It occurs in the clock where x mod 8 = 6, and `vram_addr` then holds the address of the next tile on the same line. When x = 798, the fetch targets column 0 of the next line. RAM returns the data on `vram_rdata` one clock after the pulse.
- R7: No fetch pulse occurs when the target column is 80 or beyond. No fetch pulse occurs when the target line is 480 or beyond.
- R8: While `rst_n` is low, the position is x = 0 on line 524. The outputs then read `hsync_n`=1, `vsync_n`=1, `active`=0, `colour`=0 and `vram_rd`=0. The first clock after release is x = 1 of line 524, so tile (0,0) is already fetched when line 0 begins.
- R9: After the last line of a frame, the raster returns to line 0 and the picture repeats with the same tile contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vram_rd | output | 1 | One-clock read strobe to video RAM |
| vram_addr | output | AW (13) | Tile address for the read |
| vram_rdata | input | 8 | Byte returned one clock after `vram_rd` |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | High on visible pixels |
| colour | output | 8 | Tile colour, zero in blanking |

## Verification
The assertions assume that video RAM answers every strobe with its data exactly one clock later. They also assume that `vram_rdata` stays put until the byte is captured. The bench's RAM models meet this: each registers a byte computed from the address, and only on a strobe. The tiles have no line buffer, so every fetch relies on that fixed one-clock latency. A second instance with small timing parameters lets the bench reach vertical sync and the wrap to a new frame within a short run.

// File: rtl/cellvid_pkg.sv
// Shared types and constants for the colour-cell renderer.
// Assumes square tiles whose side is a power of two.
package cellvid_pkg;
    localparam int CELL_LOG = 3;             // tile side = 2**CELL_LOG pixels
    localparam int CELL_PX  = 1 << CELL_LOG;
    typedef logic [7:0] colour_t;
endpackage

// File: rtl/cellvid_timing.sv
// Raster position counters and sync/active decode.
// Assumes every total is a multiple of the tile side and visible < total.
// Reset places the raster at the start of the last line of the frame.
module cellvid_timing #(
    parameter int HVIS = 640,
    parameter int HFP  = 16,
    parameter int HSY  = 96,
    parameter int HBP  = 48,
    parameter int VVIS = 480,
    parameter int VFP  = 10,
    parameter int VSY  = 2,
    parameter int VBP  = 33,
    localparam int HTOT = HVIS + HFP + HSY + HBP,
    localparam int VTOT = VVIS + VFP + VSY + VBP,
    localparam int HW   = $clog2(HTOT),
    localparam int VW   = $clog2(VTOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hpos,
    output logic [VW-1:0] vpos,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          active
);
    localparam logic [HW-1:0] H_LAST = HW'(HTOT - 1);
    localparam logic [HW-1:0] H_VIS  = HW'(HVIS);
    localparam logic [HW-1:0] HS_BEG = HW'(HVIS + HFP);
    localparam logic [HW-1:0] HS_END = HW'(HVIS + HFP + HSY);
    localparam logic [VW-1:0] V_LAST = VW'(VTOT - 1);
    localparam logic [VW-1:0] V_VIS  = VW'(VVIS);
    localparam logic [VW-1:0] VS_BEG = VW'(VVIS + VFP);
    localparam logic [VW-1:0] VS_END = VW'(VVIS + VFP + VSY);

    // Advance pixel counter, and line counter at end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos <= '0;
            vpos <= V_LAST;
        end else if (hpos == H_LAST) begin
            hpos <= '0;
            vpos <= (vpos == V_LAST) ? '0 : vpos + 1'b1;
        end else begin
            hpos <= hpos + 1'b1;
        end
    end

    // Decode sync pulses and visible window from the counters.
    always_comb begin
        hsync_n = !((hpos >= HS_BEG) && (hpos < HS_END));
        vsync_n = !((vpos >= VS_BEG) && (vpos < VS_END));
        active  = (hpos < H_VIS) && (vpos < V_VIS);
    end
endmodule

// File: rtl/cellvid_fetch.sv
// Tile fetch scheduler: in each tile, one read for the next tile.
// Assumes at least one blanking tile per line, so the last tile of the
// line can prefetch column 0 of the following line.
module cellvid_fetch #(
    parameter int HTOT = 800,
    parameter int VTOT = 525,
    parameter int COLS = 80,
    parameter int VVIS = 480,
    parameter int AW   = 13,
    localparam int HW  = $clog2(HTOT),
    localparam int VW  = $clog2(VTOT),
    localparam int CW  = HW - cellvid_pkg::CELL_LOG,
    localparam int RW  = VW - cellvid_pkg::CELL_LOG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hpos,
    input  logic [VW-1:0] vpos,
    output logic          vram_rd,
    output logic [AW-1:0] vram_addr
);
    import cellvid_pkg::*;
    localparam int HCELLS = HTOT / CELL_PX;
    localparam logic [CW-1:0] LAST_COL = CW'(HCELLS - 1);
    localparam logic [CW-1:0] N_COLS   = CW'(COLS);
    localparam logic [VW-1:0] V_LAST   = VW'(VTOT - 1);
    localparam logic [VW-1:0] V_VIS    = VW'(VVIS);
    localparam logic [CELL_LOG-1:0] ISSUE_PH = CELL_LOG'(CELL_PX - 3);

    logic [CW-1:0]       col, tcol;
    logic [VW-1:0]       tline;
    logic [RW-1:0]       trow;
    logic [CELL_LOG-1:0] phase;
    logic                tvalid;
    logic [AW-1:0]       taddr;

    // Work out which tile the next fetch targets and whether it is shown.
    always_comb begin
        col   = hpos[HW-1:CELL_LOG];
        phase = hpos[CELL_LOG-1:0];
        if (col == LAST_COL) begin
            tcol  = '0;
            tline = (vpos == V_LAST) ? '0 : vpos + 1'b1;
        end else begin
            tcol  = col + 1'b1;
            tline = vpos;
        end
        trow   = tline[VW-1:CELL_LOG];
        tvalid = (tcol < N_COLS) && (tline < V_VIS);
        taddr  = AW'(trow) * AW'(COLS) + AW'(tcol);
    end

    // Register the read strobe and address two clocks before the tile ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vram_rd   <= 1'b0;
            vram_addr <= '0;
        end else if (phase == ISSUE_PH) begin
            vram_rd <= tvalid;
            if (tvalid) vram_addr <= taddr;
        end else begin
            vram_rd <= 1'b0;
        end
    end
endmodule

// File: rtl/cellvid_colour.sv
// Colour stage: captures the returned tile byte on the last pixel of a
// tile and gates it to zero outside the visible window.
// Assumes RAM data is valid in the last pixel clock of the tile.
module cellvid_colour #(
    parameter int PW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PW-1:0]        phase,
    input  logic                 active,
    input  cellvid_pkg::colour_t rdata,
    output cellvid_pkg::colour_t colour
);
    cellvid_pkg::colour_t held;

    // Capture the next tile's byte at the tile boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                held <= '0;
        else if (phase == '1)      held <= rdata;
    end

    // Blank the output outside the visible window.
    always_comb colour = active ? held : '0;
endmodule

// File: rtl/cellvid_top.sv
// Colour-cell VGA renderer top: timing, tile fetch and colour stage.
// Assumes a synchronous video RAM returning data one clock after a read.
module cellvid_top #(
    parameter int HVIS = 640,
    parameter int HFP  = 16,
    parameter int HSY  = 96,
    parameter int HBP  = 48,
    parameter int VVIS = 480,
    parameter int VFP  = 10,
    parameter int VSY  = 2,
    parameter int VBP  = 33,
    parameter int AW   = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          vram_rd,
    output logic [AW-1:0] vram_addr,
    input  logic [7:0]    vram_rdata,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          active,
    output logic [7:0]    colour
);
    import cellvid_pkg::*;
    localparam int HTOT   = HVIS + HFP + HSY + HBP;
    localparam int VTOT   = VVIS + VFP + VSY + VBP;
    localparam int HW     = $clog2(HTOT);
    localparam int VW     = $clog2(VTOT);
    localparam int COLS   = HVIS / CELL_PX;
    localparam int ROWS   = VVIS / CELL_PX;
    localparam int NCELLS = COLS * ROWS;

    logic [HW-1:0] hpos;
    logic [VW-1:0] vpos;

    cellvid_timing #(
        .HVIS(HVIS), .HFP(HFP), .HSY(HSY), .HBP(HBP),
        .VVIS(VVIS), .VFP(VFP), .VSY(VSY), .VBP(VBP)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .active(active)
    );

    cellvid_fetch #(
        .HTOT(HTOT), .VTOT(VTOT), .COLS(COLS), .VVIS(VVIS), .AW(AW)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos),
        .vram_rd(vram_rd), .vram_addr(vram_addr)
    );

    cellvid_colour #(.PW(CELL_LOG)) u_colour (
        .clk(clk), .rst_n(rst_n), .phase(hpos[CELL_LOG-1:0]),
        .active(active), .rdata(vram_rdata), .colour(colour)
    );
endmodule

// File: rtl/cellvid_checker.sv
// Temporal properties of the renderer, bound onto every cellvid_top.
module cellvid_checker #(
    parameter int AW     = 13,
    parameter int NCELLS = 4800
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vram_rd,
    input logic [AW-1:0] vram_addr,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          active,
    input logic [7:0]    colour
);
    assert_hsync_in_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> !active);

    assert_vsync_in_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> !active);

    assert_fetch_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vram_rd |=> !vram_rd);

    assert_fetch_addr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vram_rd |-> (vram_addr < AW'(NCELLS)));

    assert_colour_change_after_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && (colour != $past(colour))) |-> $past(vram_rd, 2));
endmodule

bind cellvid_top cellvid_checker #(.AW(AW), .NCELLS(NCELLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .vram_rd(vram_rd), .vram_addr(vram_addr),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .active(active), .colour(colour)
);

// File: tb/cellvid_top_bench.sv
module cellvid_top_bench;
    localparam int CLK_PERIOD = 40;
    localparam int WATCHDOG   = 150000;
    localparam int NVEC       = 16;
    // Visible-area sample points (x, y), in raster order.
    localparam int VX [NVEC] = '{0, 7, 8, 639, 640, 655, 656, 751, 752, 799, 3, 8, 15, 635, 0, 320};
    localparam int VY [NVEC] = '{0, 0, 0, 0,   0,   0,   0,   0,   0,   799 - 799, 5, 8, 15, 16, 23, 23};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;

    logic        rd_a, hs_a, vs_a, act_a;
    logic [12:0] addr_a;
    logic [7:0]  rdata_a, col_a;
    logic        rd_b, hs_b, vs_b, act_b;
    logic [7:0]  addr_b, rdata_b, col_b;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Synchronous video RAM models: data one clock after a strobe.
    always @(posedge clk) if (rd_a) rdata_a <= pat(int'(addr_a));
    always @(posedge clk) if (rd_b) rdata_b <= pat(int'(addr_b));

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    cellvid_top u_cellvid_top (
        .clk(clk), .rst_n(rst_n), .vram_rd(rd_a), .vram_addr(addr_a),
        .vram_rdata(rdata_a), .hsync_n(hs_a), .vsync_n(vs_a),
        .active(act_a), .colour(col_a)
    );

    // Small raster: 96 x 24 total, 64 x 16 visible, 8 x 2 tiles.
    cellvid_top #(
        .HVIS(64), .HFP(8), .HSY(16), .HBP(8),
        .VVIS(16), .VFP(2), .VSY(2), .VBP(4), .AW(8)
    ) u_small (
        .clk(clk), .rst_n(rst_n), .vram_rd(rd_b), .vram_addr(addr_b),
        .vram_rdata(rdata_b), .hsync_n(hs_b), .vsync_n(vs_b),
        .active(act_b), .colour(col_b)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic goto(input int k);
        while (cyc != k) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8", "hsync_n in reset", int'(hs_a), 1);
        chk("R8", "vsync_n in reset", int'(vs_a), 1);
        chk("R8", "active in reset", int'(act_a), 0);
        chk("R8", "colour in reset", int'(col_a), 0);
        chk("R8", "vram_rd in reset", int'(rd_a), 0);
        rst_n = 1'b1;
    endtask

    // Small raster position k = 96*(y+1 + 24*frame) + x.
    function automatic int ks(input int x, input int y, input int f);
        return 96 * (y + 1 + 24 * f) + x;
    endfunction

    function automatic int km(input int x, input int y);
        return 800 * (y + 1) + x;
    endfunction

    initial begin
        // ---- small raster: vertical sync, fetch suppression, frame wrap
        do_reset();
        goto(ks(0, 0, 0));  chk("R8", "first line tile colour", int'(col_b), int'(pat(0)));
        goto(ks(94, 15, 0)); chk("R7", "no fetch for hidden line", int'(rd_b), 0);
        goto(ks(0, 17, 0)); chk("R2", "vsync_n before pulse", int'(vs_b), 1);
        goto(ks(0, 18, 0)); chk("R2", "vsync_n first sync line", int'(vs_b), 0);
        goto(ks(6, 18, 0)); chk("R7", "no fetch in vertical blank", int'(rd_b), 0);
        goto(ks(95, 19, 0)); chk("R2", "vsync_n end of second line", int'(vs_b), 0);
        goto(ks(0, 20, 0)); chk("R2", "vsync_n after pulse", int'(vs_b), 1);
        goto(ks(94, 23, 0));
        chk("R6", "wrap fetch strobe", int'(rd_b), 1);
        chk("R6", "wrap fetch address", int'(addr_b), 0);
        goto(ks(0, 0, 1));  chk("R9", "new frame tile 0", int'(col_b), int'(pat(0)));
        goto(ks(63, 15, 1)); chk("R9", "new frame last tile", int'(col_b), int'(pat(15)));
        goto(ks(64, 15, 1)); chk("R5", "small colour blank", int'(col_b), 0);

        // ---- full raster: vector table walk
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            automatic int x = VX[i];
            automatic int y = VY[i];
            automatic bit vis = (x < 640) && (y < 480);
            goto(km(x, y));
            chk("R3", $sformatf("active x=%0d y=%0d", x, y), int'(act_a), int'(vis));
            chk("R1", $sformatf("hsync_n x=%0d", x), int'(hs_a), int'(!(x >= 656 && x < 752)));
            chk("R2", "vsync_n in visible band", int'(vs_a), 1);
            if (vis) chk("R4", $sformatf("colour x=%0d y=%0d", x, y), int'(col_a),
                         int'(pat((y / 8) * 80 + x / 8)));
            else     chk("R5", $sformatf("colour blank x=%0d", x), int'(col_a), 0);
        end

        // ---- fetch schedule directed checks (row 3 of tiles)
        goto(km(30, 24));
        chk("R6", "strobe at phase 6", int'(rd_a), 1);
        chk("R6", "address of next tile", int'(addr_a), 244);
        goto(km(31, 24)); chk("R6", "strobe is one clock", int'(rd_a), 0);
        goto(km(630, 24));
        chk("R6", "strobe for last column", int'(rd_a), 1);
        chk("R6", "address of last column", int'(addr_a), 319);
        goto(km(638, 24)); chk("R7", "no fetch past column 79", int'(rd_a), 0);
        goto(km(702, 24)); chk("R7", "no fetch in blank tile", int'(rd_a), 0);
        goto(km(798, 31));
        chk("R6", "end-of-line fetch strobe", int'(rd_a), 1);
        chk("R6", "end-of-line fetch address", int'(addr_a), 320);
        goto(km(0, 32)); chk("R4", "first tile of new row", int'(col_a), int'(pat(320)));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule